// File: doc/BRIEF.md
# Channel Interrupt Status Controller

This block gathers per-channel interrupt events for a bank of DMA-style channels. The default is 64 channels. Each channel delivers a one-cycle completion pulse and a one-cycle error pulse. Either pulse latches a pending bit for that channel. The pending bits sit in 32-bit status words that a host reads and clears over a simple single-cycle register port.

Each status word drives its own level interrupt request line. A merge control folds every word onto line 0 and holds the other lines low. A clear-mode control picks how the host retires pending bits:
- **Clear-on-read:** the word is cleared as it is read.
- **Write-one-to-clear:** the host writes ones to the bits it wants cleared.

Top module: `chan_irq_status`

## Requirements
- R1: The status word at address 0 holds channels 0 to 31 and the word at address 1 holds channels 32 to 63. Bit n of word w stands for channel 32*w+n. `host_rdata` shows the addressed word, combinationally, in the cycle `host_rd` is 1, and is zero otherwise.
- R2: A 1 on `chan_done[c]` or `chan_err[c]` at a clock edge leaves the pending bit of channel c set after that edge.
- R3: With `merge_en`=0, `irq[0]` is 1 exactly when word 0 held any pending bit at the previous edge, and `irq[1]` likewise for word 1. The lines are registered one cycle after the status they reflect.
- R4: With `merge_en`=1, `irq[0]` is 1 when any pending bit in either word was set at the previous edge, and `irq[1]` is 0.
- R5: With `clr_w1c`=0, a read clears every bit that the read returned.
- R6: With `clr_w1c`=1, a write clears the bits where `host_wdata` is 1 and leaves the bits where it is 0.
- R7: Reset (`rst`=1, synchronous) clears both status words and both interrupt lines.
- R8: An event that arrives in the same cycle as a clear of its bit, whether by read or by write, wins. The bit stays pending.
- R9: With `clr_w1c`=0, host writes change no status bit. With `clr_w1c`=1, host reads change no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_done | input | 64 | Per-channel completion pulse |
| chan_err | input | 64 | Per-channel error pulse |
| merge_en | input | 1 | 1: all words drive irq[0] |
| clr_w1c | input | 1 | 0: clear on read, 1: write one to clear |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_addr | input | 1 | Status word index |
| host_wdata | input | 32 | Write data (clear mask) |
| host_rdata | output | 32 | Read data |
| irq | output | 2 | Interrupt request lines |

## Verification
Directed sequences cover several distinguishing cases:
- a single low channel and a single high channel, which tell the word split apart;
- done-only and error-only pulses;
- a read or write that collides with a fresh event on the same bit, which separates set priority from clear priority;
- writes in clear-on-read mode and reads in write-one-to-clear mode, which must leave the status untouched.

Random sparse events, random host accesses and random clear masks run with the mode and merge controls changed every few hundred cycles. This shows that line 1 follows the merge control and that only the masked bits clear.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;

   typedef enum logic {
      CLR_ON_READ = 1'b0,
      CLR_BY_W1C  = 1'b1
   } clr_mode_e;

   function automatic int unsigned addr_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/chan_irq_word.sv
module chan_irq_word
   import chan_irq_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] ev_set,
   input  logic              rd_hit,
   input  logic              wr_hit,
   input  logic [WORD_W-1:0] wr_mask,
   input  clr_mode_e         mode,
   output logic [WORD_W-1:0] st_q
);

   logic [WORD_W-1:0] clr_mask;
   logic [WORD_W-1:0] st_d;

   // Clear source depends on the mode; the other access type is inert.
   always_comb begin
      clr_mask = '0;
      unique case (mode)
         CLR_ON_READ: if (rd_hit) clr_mask = st_q;
         CLR_BY_W1C:  if (wr_hit) clr_mask = wr_mask;
         default:     clr_mask = '0;
      endcase
   end

   // Set has priority over a clear hitting the same bit.
   assign st_d = (st_q & ~clr_mask) | ev_set;

   always_ff @(posedge clk) begin
      if (rst) st_q <= '0;
      else     st_q <= st_d;
   end

endmodule

// File: rtl/chan_irq_busdec.sv
module chan_irq_busdec #(
   parameter int unsigned NUM_WORDS = 2,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned ADDR_W    = 1
) (
   input  logic                        host_rd,
   input  logic                        host_wr,
   input  logic [ADDR_W-1:0]           host_addr,
   input  logic [NUM_WORDS*WORD_W-1:0] st_flat,
   output logic [NUM_WORDS-1:0]        rd_hit,
   output logic [NUM_WORDS-1:0]        wr_hit,
   output logic [WORD_W-1:0]           host_rdata
);

   logic [NUM_WORDS-1:0] sel;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
      assign sel[w]    = (host_addr == ADDR_W'(w));
      assign rd_hit[w] = host_rd & sel[w];
      assign wr_hit[w] = host_wr & sel[w];
   end

   always_comb begin
      host_rdata = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (rd_hit[w]) host_rdata = st_flat[w*WORD_W +: WORD_W];
      end
   end

endmodule

// File: rtl/chan_irq_reqgen.sv
module chan_irq_reqgen #(
   parameter int unsigned NUM_WORDS   = 2,
   parameter int unsigned WORD_W      = 32,
   parameter bit          ALLOW_MERGE = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        merge_en,
   input  logic [NUM_WORDS*WORD_W-1:0] st_flat,
   output logic [NUM_WORDS-1:0]        irq
);

   logic [NUM_WORDS-1:0] any_pend;
   logic [NUM_WORDS-1:0] irq_d;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_any
      assign any_pend[w] = |st_flat[w*WORD_W +: WORD_W];
   end

   if (ALLOW_MERGE) begin : g_merge
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_line
         if (w == 0) begin : g_first
            assign irq_d[w] = merge_en ? (|any_pend) : any_pend[0];
         end else begin : g_rest
            assign irq_d[w] = ~merge_en & any_pend[w];
         end
      end
   end else begin : g_split
      assign irq_d = any_pend;
   end

   always_ff @(posedge clk) begin
      if (rst) irq <= '0;
      else     irq <= irq_d;
   end

endmodule

// File: rtl/chan_irq_status.sv
module chan_irq_status
   import chan_irq_pkg::*;
#(
   parameter int unsigned NUM_CH      = 64,
   parameter int unsigned WORD_W      = 32,
   parameter bit          ALLOW_MERGE = 1'b1,
   localparam int unsigned NUM_WORDS  = NUM_CH / WORD_W,
   localparam int unsigned ADDR_W     = addr_bits(NUM_CH / WORD_W)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_CH-1:0]    chan_done,
   input  logic [NUM_CH-1:0]    chan_err,
   input  logic                 merge_en,
   input  logic                 clr_w1c,
   input  logic                 host_rd,
   input  logic                 host_wr,
   input  logic [ADDR_W-1:0]    host_addr,
   input  logic [WORD_W-1:0]    host_wdata,
   output logic [WORD_W-1:0]    host_rdata,
   output logic [NUM_WORDS-1:0] irq
);

   if (WORD_W == 0 || NUM_CH == 0) begin : g_bad_size
      $error("chan_irq_status: NUM_CH and WORD_W must be non-zero");
   end
   if ((NUM_CH % WORD_W) != 0) begin : g_bad_split
      $error("chan_irq_status: NUM_CH must be a multiple of WORD_W");
   end

   logic [NUM_CH-1:0]    ev_any;
   logic [NUM_CH-1:0]    st_flat;
   logic [NUM_WORDS-1:0] rd_hit;
   logic [NUM_WORDS-1:0] wr_hit;
   clr_mode_e            mode;

   assign ev_any = chan_done | chan_err;
   assign mode   = clr_w1c ? CLR_BY_W1C : CLR_ON_READ;

   chan_irq_busdec #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_W    (WORD_W),
      .ADDR_W    (ADDR_W)
   ) u_dec (
      .host_rd    (host_rd),
      .host_wr    (host_wr),
      .host_addr  (host_addr),
      .st_flat    (st_flat),
      .rd_hit     (rd_hit),
      .wr_hit     (wr_hit),
      .host_rdata (host_rdata)
   );

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      chan_irq_word #(
         .WORD_W (WORD_W)
      ) u_word (
         .clk     (clk),
         .rst     (rst),
         .ev_set  (ev_any[w*WORD_W +: WORD_W]),
         .rd_hit  (rd_hit[w]),
         .wr_hit  (wr_hit[w]),
         .wr_mask (host_wdata),
         .mode    (mode),
         .st_q    (st_flat[w*WORD_W +: WORD_W])
      );
   end

   chan_irq_reqgen #(
      .NUM_WORDS   (NUM_WORDS),
      .WORD_W      (WORD_W),
      .ALLOW_MERGE (ALLOW_MERGE)
   ) u_req (
      .clk      (clk),
      .rst      (rst),
      .merge_en (merge_en),
      .st_flat  (st_flat),
      .irq      (irq)
   );

endmodule

// File: rtl/chan_irq_status_chk.sv
module chan_irq_status_chk #(
   parameter int unsigned NUM_CH    = 64,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_WORDS = 2
) (
   input logic                 clk,
   input logic                 rst,
   input logic [NUM_CH-1:0]    chan_done,
   input logic [NUM_CH-1:0]    chan_err,
   input logic                 merge_en,
   input logic                 clr_w1c,
   input logic                 host_rd,
   input logic                 host_wr,
   input logic [NUM_CH-1:0]    st_flat,
   input logic [NUM_WORDS-1:0] irq
);

   logic [NUM_CH-1:0] ev;
   logic              rst_d;

   assign ev = chan_done | chan_err;

   always_ff @(posedge clk) rst_d <= rst;

   // R7: one edge after reset is seen, status is empty.
   always_ff @(posedge clk) begin
      if (rst_d) assert_reset_clear_R7: assert (st_flat == '0);
   end

   // R2 / R8: an event always leaves its bit set, whatever clear is active.
   assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
      (ev != '0) |=> ((st_flat & $past(ev)) == $past(ev)));

   // R6: in write-one-to-clear mode nothing falls without a write.
   assert_w1c_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (clr_w1c && !host_wr) |=> ((st_flat & $past(st_flat)) == $past(st_flat)));

   // R9: in clear-on-read mode nothing falls without a read.
   assert_cor_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (!clr_w1c && !host_rd) |=> ((st_flat & $past(st_flat)) == $past(st_flat)));

   // R4: merged lines leave the upper line idle.
   assert_merge_idle_R4: assert property (@(posedge clk) disable iff (rst)
      merge_en |=> (irq[NUM_WORDS-1:1] == '0));

   // R3: the first line follows the low word one cycle later when split.
   assert_line0_R3: assert property (@(posedge clk) disable iff (rst)
      (!merge_en && (st_flat[WORD_W-1:0] != '0)) |=> irq[0]);

endmodule

bind chan_irq_status chan_irq_status_chk #(
   .NUM_CH    (NUM_CH),
   .WORD_W    (WORD_W),
   .NUM_WORDS (NUM_WORDS)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .chan_done (chan_done),
   .chan_err  (chan_err),
   .merge_en  (merge_en),
   .clr_w1c   (clr_w1c),
   .host_rd   (host_rd),
   .host_wr   (host_wr),
   .st_flat   (st_flat),
   .irq       (irq)
);

// File: tb/test_chan_irq_status.sv
module test_chan_irq_status;

   logic        clk = 1'b0;
   logic        rst;
   logic [63:0] chan_done, chan_err;
   logic        merge_en, clr_w1c;
   logic        host_rd, host_wr;
   logic [0:0]  host_addr;
   logic [31:0] host_wdata;
   logic [31:0] host_rdata;
   logic [1:0]  irq;

   int n_run  = 0;
   int n_fail = 0;

   logic [31:0] m_st [2];
   logic [1:0]  m_irq;

   always #10 clk = ~clk;

   chan_irq_status i_chan_irq_status (
      .clk(clk), .rst(rst), .chan_done(chan_done), .chan_err(chan_err),
      .merge_en(merge_en), .clr_w1c(clr_w1c), .host_rd(host_rd),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_irq(input logic [31:0] s0, input logic [31:0] s1,
                                          input logic mg);
      return mg ? {1'b0, (|s0) | (|s1)} : {|s1, |s0};
   endfunction

   function automatic logic [31:0] next_word(input logic [31:0] s, input logic [31:0] ev,
                                             input logic w1c, input logic rd,
                                             input logic wr, input logic [31:0] wd);
      logic [31:0] clr;
      clr = w1c ? (wr ? wd : 32'h0) : (rd ? s : 32'h0);
      return (s & ~clr) | ev;
   endfunction

   // One cycle, starting and ending at a falling edge.
   task automatic cycle(input string req, input logic rd, input logic wr, input logic a,
                        input logic [31:0] wd, input logic [63:0] dn, input logic [63:0] er);
      logic [63:0] ev;
      logic [31:0] n0, n1;
      host_rd = rd; host_wr = wr; host_addr = a; host_wdata = wd;
      chan_done = dn; chan_err = er;
      #1;
      check({req, " rdata"}, host_rdata, rd ? m_st[a] : 32'h0);
      ev = dn | er;
      n0 = next_word(m_st[0], ev[31:0],  clr_w1c, rd && a == 1'b0, wr && a == 1'b0, wd);
      n1 = next_word(m_st[1], ev[63:32], clr_w1c, rd && a == 1'b1, wr && a == 1'b1, wd);
      @(posedge clk);
      m_irq = exp_irq(m_st[0], m_st[1], merge_en);
      m_st[0] = n0; m_st[1] = n1;
      @(negedge clk);
      check({req, " irq"}, {30'h0, irq}, {30'h0, m_irq});
   endtask

   task automatic idle(input string req);
      cycle(req, 1'b0, 1'b0, 1'b0, 32'h0, 64'h0, 64'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_c0de));
      rst = 1'b1; merge_en = 1'b0; clr_w1c = 1'b0;
      host_rd = 1'b0; host_wr = 1'b0; host_addr = 1'b0; host_wdata = '0;
      chan_done = '0; chan_err = '0;
      m_st[0] = '0; m_st[1] = '0; m_irq = '0;
      // R7: events during reset are discarded, reset state is zero
      chan_done = '1;
      repeat (3) @(negedge clk);
      chan_done = '0;
      @(negedge clk);
      rst = 1'b0;
      check("R7 irq", {30'h0, irq}, 32'h0);
      cycle("R7", 1'b1, 1'b0, 1'b0, 32'h0, 64'h0, 64'h0);
      cycle("R7", 1'b1, 1'b0, 1'b1, 32'h0, 64'h0, 64'h0);

      // R1 R2 R3: done on channel 5, error on channel 40
      cycle("R2", 1'b0, 1'b0, 1'b0, 32'h0, 64'h1 << 5, 64'h0);
      idle("R3");
      cycle("R2", 1'b0, 1'b0, 1'b0, 32'h0, 64'h0, 64'h1 << 40);
      idle("R3");
      // R1: word split visible, R5: clear-on-read empties word
      cycle("R1", 1'b1, 1'b0, 1'b1, 32'h0, 64'h0, 64'h0);
      cycle("R5", 1'b1, 1'b0, 1'b1, 32'h0, 64'h0, 64'h0);
      // R8: read collides with a fresh event on the same bit
      cycle("R8", 1'b1, 1'b0, 1'b0, 32'h0, 64'h1 << 5, 64'h0);
      cycle("R8", 1'b1, 1'b0, 1'b0, 32'h0, 64'h0, 64'h0);
      // R9: write in clear-on-read mode changes nothing
      cycle("R9", 1'b0, 1'b0, 1'b0, 32'h0, 64'h0, 64'h3 << 60);
      cycle("R9", 1'b0, 1'b1, 1'b1, 32'hffff_ffff, 64'h0, 64'h0);
      cycle("R9", 1'b1, 1'b0, 1'b1, 32'h0, 64'h0, 64'h0);

      // R6: write-one-to-clear
      clr_w1c = 1'b1;
      cycle("R6", 1'b0, 1'b0, 1'b0, 32'h0, 64'h0000_00f0_0000_0f00, 64'h0);
      cycle("R9", 1'b1, 1'b0, 1'b0, 32'h0, 64'h0, 64'h0);
      cycle("R9", 1'b1, 1'b0, 1'b0, 32'h0, 64'h0, 64'h0);
      cycle("R6", 1'b0, 1'b1, 1'b0, 32'h0000_0300, 64'h0, 64'h0);
      cycle("R6", 1'b1, 1'b0, 1'b0, 32'h0, 64'h0, 64'h0);
      cycle("R8", 1'b0, 1'b1, 1'b0, 32'h0000_0c00, 64'h1 << 11, 64'h0);
      cycle("R8", 1'b1, 1'b0, 1'b0, 32'h0, 64'h0, 64'h0);

      // R4: merge, only high word pending
      cycle("R6", 1'b0, 1'b1, 1'b0, 32'hffff_ffff, 64'h0, 64'h0);
      merge_en = 1'b1;
      idle("R4");
      idle("R4");
      cycle("R4", 1'b0, 1'b1, 1'b1, 32'hffff_ffff, 64'h0, 64'h0);
      idle("R4");
      merge_en = 1'b0;
      cycle("R3", 1'b0, 1'b0, 1'b0, 32'h0, 64'h1 << 63, 64'h0);
      idle("R3");
      idle("R3");

      // Random phase: sparse events, random access, mode changes
      for (int i = 0; i < 6000; i++) begin
         logic [63:0] dn, er;
         logic        rd, wr;
         if (i % 400 == 0) begin
            merge_en = 1'($urandom);
            clr_w1c  = 1'($urandom);
         end
         dn = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
              & {$urandom, $urandom};
         er = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
              & {$urandom, $urandom} & {$urandom, $urandom};
         if ($urandom % 3 != 0) begin dn = '0; er = '0; end
         rd = ($urandom % 4) == 0;
         wr = ($urandom % 4) == 0;
         cycle("R1 R2 R3 R4 R5 R6 R8 R9 random", rd, wr, 1'($urandom), $urandom, dn, er);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule